// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps the time of day and the calendar date in packed BCD across eight byte-wide registers. A one-cycle pulse on `tick`, once per second, advances the time. The seconds, minutes and hours cascade into day of week, date, month and year, and a century flag can invert when the year wraps. A host reaches the registers through a byte port made of a 3-bit address, a write strobe, write data and combinational read data. Address 7 is a control byte that the time-keeping logic never touches.

While the host reads the time, it raises `rd_busy`. The values it sees on addresses 0 to 6 then hold still, even if a tick arrives in the middle of a multi-byte read. The running time keeps advancing behind the frozen copy. One clock edge after `rd_busy` drops, the visible copy catches up, so no second is lost. A stop flag in the seconds byte halts counting, for example while the time is being set.

Top module: `rtc_bcd_regs`

## Requirements
- R1: After reset, addresses 0 to 7 read 00, 00, 00, 01, 01, 01, 00, 00 (hex). The stop flag, the century-enable flag and the century flag are all 0.
- R2: Each tick advances the seconds (address 0, bits 6:0) by one in BCD. Seconds wrap from 59 to 00 and carry into the minutes (address 1, bits 6:0), which wrap from 59 to 00. Minutes carry into the hours (address 2, bits 5:0), which wrap from 23 to 00.
- R3: The day of week (address 3, bits 2:0) counts 1 to 7, advances each time the hours wrap, and goes from 7 back to 1.
- R4: The date (address 4, bits 5:0) wraps to 01 at midnight after the last day of the month. The last day is day 31 for months 01, 03, 05, 07, 08, 10 and 12, and day 30 for months 04, 06, 09 and 11. For month 02 it is day 29 when the year value is divisible by 4, and day 28 otherwise.
- R5: The month (address 5, bits 4:0) advances when the date wraps and goes from 12 to 01. The year (address 6) advances when the month wraps and goes from 99 to 00.
- R6: Address 2 bit 7 is the century enable and bit 6 is the century flag. When the enable is 1, the flag inverts each time the year wraps from 99 to 00. When the enable is 0, the flag never changes except by a host write.
- R7: While address 0 bit 7 (the stop flag) is 1, ticks do not change any time register. After the flag is cleared, the next tick advances the time again.
- R8: Address 7 reads back the last byte written to it and is never changed by the time-keeping logic.
- R9: While `rd_busy` is 1, the bytes read on addresses 0 to 6 do not change. Ticks still advance the running time. On the first clock edge where `rd_busy` is sampled 0, the visible bytes take the running time.
- R10: A write to addresses 0 to 6 loads the running time at that clock edge and wins over a tick in the same cycle. The written byte is readable after one more edge. Unused bits read 0: address 1 bit 7, address 3 bits 7:3, address 4 bits 7:6 and address 5 bits 7:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse, once per second |
| addr | input | 3 | Register address 0 to 7 |
| wr_en | input | 1 | Write strobe for the byte at `addr` |
| wr_data | input | 8 | Byte to write |
| rd_busy | input | 1 | High while the host reads the time registers |
| rd_data | output | 8 | Byte at `addr` (visible copy for 0 to 6, control for 7) |

## Verification
The assertions assume that the host does not write to the time registers while `rd_busy` is high. If it did, the running time could move while the visible copy stays frozen, which the freeze property allows, but the written value would only show after the read. The assertions also assume that every written value is legal BCD within its field's range, because the carry logic only compares against the terminal values. The stimulus writes only legal BCD values, never holds `rd_busy` during a write, and drives `tick` as a single-cycle pulse placed away from the clock edge.

// File: rtl/rtc_bcd_regs.sv
module rtc_bcd_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_busy,
  output logic [7:0] rd_data
);

  logic [6:0][7:0] lv, vis, nx;
  logic [7:0] ctrl;
  logic [7:0] hr_inc;
  logic run, s_wr, m_wr, h_wr, d_wr, mo_wr, y_wr;
  logic [5:0] last_day;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : v + 8'd1;
  endfunction

  function automatic logic [5:0] month_len(input logic [4:0] m, input logic [7:0] y);
    logic [6:0] yb;
    yb = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    case (m)
      5'h02: return (yb[1:0] == 2'd0) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
      default: return 6'h31;
    endcase
  endfunction

  function automatic logic [7:0] wmask(input logic [2:0] a);
    case (a)
      3'd1: return 8'h7F;
      3'd3: return 8'h07;
      3'd4: return 8'h3F;
      3'd5: return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  assign run      = tick && !lv[0][7];
  assign last_day = month_len(lv[5][4:0], lv[6]);
  assign s_wr     = run  && lv[0][6:0] == 7'h59;
  assign m_wr     = s_wr && lv[1][6:0] == 7'h59;
  assign h_wr     = m_wr && lv[2][5:0] == 6'h23;
  assign d_wr     = h_wr && lv[4][5:0] == last_day;
  assign mo_wr    = d_wr && lv[5][4:0] == 5'h12;
  assign y_wr     = mo_wr && lv[6] == 8'h99;
  assign hr_inc   = bcd_inc({2'b00, lv[2][5:0]});

  always_comb begin
    nx = lv;
    if (run)  nx[0] = s_wr ? 8'h00 : bcd_inc(lv[0]);
    if (s_wr) nx[1] = m_wr ? 8'h00 : bcd_inc(lv[1]);
    if (m_wr) nx[2] = {lv[2][7], lv[2][6] ^ (lv[2][7] & y_wr), h_wr ? 6'h00 : hr_inc[5:0]};
    if (h_wr) nx[3] = (lv[3][2:0] == 3'd7) ? 8'h01 : lv[3] + 8'd1;
    if (h_wr) nx[4] = d_wr ? 8'h01 : bcd_inc(lv[4]);
    if (d_wr) nx[5] = mo_wr ? 8'h01 : bcd_inc(lv[5]);
    if (mo_wr) nx[6] = y_wr ? 8'h00 : bcd_inc(lv[6]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lv   <= {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
      vis  <= {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
      ctrl <= 8'h00;
    end else begin
      if (wr_en && addr != 3'd7) begin
        lv <= nx;
        lv[addr] <= wr_data & wmask(addr);
      end else begin
        lv <= nx;
      end
      if (wr_en && addr == 3'd7) ctrl <= wr_data;
      if (!rd_busy) vis <= lv;
    end
  end

  assign rd_data = (addr == 3'd7) ? ctrl : vis[addr];

  // R9
  frozen_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_busy |=> $stable(vis));

  // R8
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 3'd7) |=> $stable(ctrl));

  // R7
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lv[0][7] && !wr_en) |=> $stable(lv));

  // R6
  century_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lv[2][7] && !(wr_en && addr == 3'd2)) |=> $stable(lv[2][6]));

endmodule

// File: tb/rtc_bcd_regs_test.sv
module rtc_bcd_regs_test;
  localparam int PERIOD = 10;
  localparam int NVEC = 10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_busy = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  rtc_bcd_regs uut (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wr_en(wr_en),
                    .wr_data(wr_data), .rd_busy(rd_busy), .rd_data(rd_data));

  always #(PERIOD/2) clk = ~clk;

  // {start yr,mo,dt,dow,hr,mn,sc , expected yr,mo,dt,dow,hr,mn,sc}
  localparam logic [111:0] VEC [NVEC] = '{
    {56'h00_01_01_01_00_00_00, 56'h00_01_01_01_00_00_01},
    {56'h99_12_31_07_A3_59_59, 56'h00_01_01_01_C0_00_00},
    {56'h01_02_28_03_23_59_59, 56'h01_03_01_04_00_00_00},
    {56'h24_02_28_03_23_59_59, 56'h24_02_29_04_00_00_00},
    {56'h23_04_30_02_23_59_59, 56'h23_05_01_03_00_00_00},
    {56'h05_06_15_02_52_09_59, 56'h05_06_15_02_52_10_00},
    {56'h99_12_31_05_63_59_59, 56'h00_01_01_06_40_00_00},
    {56'h10_08_31_04_09_59_59, 56'h10_08_31_04_10_00_00},
    {56'h24_02_29_01_23_59_59, 56'h24_03_01_02_00_00_00},
    {56'h19_12_31_06_23_59_59, 56'h20_01_01_07_00_00_00}
  };

  task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string req);
    addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s addr %0d: got %h expected %h", req, a, rd_data, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse();
    tick = 1'b1;
    @(posedge clk); @(negedge clk);
    tick = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    chk(0, 8'h00, "R1"); chk(1, 8'h00, "R1"); chk(2, 8'h00, "R1"); chk(3, 8'h01, "R1");
    chk(4, 8'h01, "R1"); chk(5, 8'h01, "R1"); chk(6, 8'h00, "R1"); chk(7, 8'h00, "R1");

    // R2 R3 R4 R5 R6 vector walk
    for (int i = 0; i < NVEC; i++) begin
      for (int k = 0; k < 7; k++) wr(3'(k), VEC[i][56 + 8*k +: 8]);
      pulse();
      for (int k = 0; k < 7; k++)
        chk(3'(k), VEC[i][8*k +: 8], $sformatf("R2 R3 R4 R5 R6 vec%0d", i));
    end

    // R7 stop flag
    wr(0, 8'h90);
    pulse(); pulse(); pulse();
    chk(0, 8'h90, "R7 stopped");
    wr(0, 8'h10);
    pulse();
    chk(0, 8'h11, "R7 resumed");

    // R8 control byte survives a full rollover
    wr(7, 8'h5A);
    wr(6, 8'h99); wr(5, 8'h12); wr(4, 8'h31); wr(2, 8'h23); wr(1, 8'h59); wr(0, 8'h59);
    pulse();
    chk(7, 8'h5A, "R8");
    chk(6, 8'h00, "R8 rollover happened");

    // R9 read freeze and catch-up
    wr(1, 8'h20); wr(0, 8'h05);
    @(posedge clk); @(negedge clk);
    rd_busy = 1'b1;
    pulse(); pulse();
    chk(0, 8'h05, "R9 frozen");
    chk(1, 8'h20, "R9 frozen");
    rd_busy = 1'b0;
    chk(0, 8'h05, "R9 before edge");
    @(posedge clk); @(negedge clk);
    chk(0, 8'h07, "R9 caught up");

    // R10 write beats tick, masks
    addr = 3'd0; wr_data = 8'h30; wr_en = 1'b1; tick = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(0, 8'h30, "R10 write wins");
    wr(1, 8'h85); @(posedge clk); @(negedge clk);
    chk(1, 8'h05, "R10 mask min");
    wr(3, 8'hF4); @(posedge clk); @(negedge clk);
    chk(3, 8'h04, "R10 mask dow");
    wr(4, 8'hD2); @(posedge clk); @(negedge clk);
    chk(4, 8'h12, "R10 mask date");
    wr(5, 8'hE9); @(posedge clk); @(negedge clk);
    chk(5, 8'h09, "R10 mask month");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule